// File: doc/BRIEF.md
# E1 Receive Master-Mode Timing Generator

This block produces the system-side timing for one E1 receive link when the link itself is the timing master. A reference clock at twice the bit rate drives it. Each reference cycle is one half-bit. From that reference the block derives the serial bit clock, a frame pulse, serial data and serial signaling. Payload bytes and signaling nibbles come from an external per-timeslot store. The block addresses that store through a fetch port that names the timeslot and the frame being launched.

In full mode the bit clock runs without a break through all 32 timeslots. In fractional mode the clock is held low during selected timeslots, or only during the last bit (bit 8) of selected timeslots. The frame pulse can mark:
- the start of every frame,
- the start of the CRC multiframe,
- the start of the signaling multiframe,
- the start of either multiframe,
- the two overhead timeslots.

Its active level is selectable. Two edge selects place the pulse and the data on the falling or rising edge of the bit clock. When the two selects differ, the pulse leads the data by half a bit.

Top module: `e1rm_rx_master_timing`

## Requirements
- R1: While `rst` is high, all four serial outputs are 0 and the half-bit position is 0. The n-th rising edge after `rst` falls loads the outputs for half n.
- R2: Half positions count 0..8191 and then wrap. The bit index is half/2. Bit position within the timeslot is bit%8 and timeslot is (bit/8)%32. The frame within the 16-frame multiframe is bit/256. When ungapped, `sclk_o` is low in even halves and high in odd halves, so it is never high in two adjacent halves.
- R3: With `gap_en`=1 and `gap_ts`=1, `sclk_o` stays low for all 16 halves of every timeslot t whose `gap_mask[t]` is 1. This applies whatever `gap_b8` is.
- R4: With `gap_en`=1, `gap_ts`=0 and `gap_b8`=1, `sclk_o` is low only during bit position 7 of the timeslots selected by `gap_mask`.
- R5: With `gap_en`=0, `gap_ts`, `gap_b8` and `gap_mask` have no effect, and the clock toggles every half.
- R6: Data is sent MSB first. Bit b carries `fetch_data[7 - b%8]` of the byte returned for `fetch_ts`=(b/8)%32 and `fetch_frm`=b/256. With `dat_edge`=0 it changes at the start of half 2b (falling clock edge). With `dat_edge`=1 it changes at half 2b+1 (rising edge). In gapped bits, `sdat_o` and `ssig_o` are 0.
- R7: Signaling is aligned per timeslot with the data. Bit positions 0..3 carry `fetch_sig[3]`..`fetch_sig[0]`, positions 4..7 carry 0, and the timing is the same as the data.
- R8: The pulse for bit b changes at half 2b when `fp_edge`=0 (falling edge) and at half 2b-1 when `fp_edge`=1 (rising edge), so it leads the data by one half when the edge selects differ.
- R9: The `fp_sel` code picks the pulse meaning:
  - 0: bit 0 of timeslot 0 in every frame.
  - 1: the same bit in frame 0 only.
  - 2: the same bit in frame `smf_align` only.
  - 3: either of codes 1 and 2.
  - 4: every bit of timeslots 0 and 16.
  - 5 to 7: never active.
- R10: `sfp_o` is the active indication XOR `fp_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, two cycles per bit |
| rst | input | 1 | Synchronous reset, active high |
| gap_en | input | 1 | Qualifies both gap selects |
| gap_ts | input | 1 | Gap whole selected timeslots |
| gap_b8 | input | 1 | Gap bit 8 of selected timeslots |
| gap_mask | input | 32 | One bit per timeslot selected for gapping |
| fp_sel | input | 3 | Frame pulse meaning code |
| fp_inv | input | 1 | Inverts frame pulse level |
| fp_edge | input | 1 | Pulse edge: 0 falling, 1 rising |
| dat_edge | input | 1 | Data edge: 0 falling, 1 rising |
| smf_align | input | 4 | Frame number where the signaling multiframe starts |
| fetch_ts | output | 5 | Timeslot of the bit being launched |
| fetch_frm | output | 4 | Frame of the bit being launched |
| fetch_data | input | 8 | Payload byte for the fetched slot |
| fetch_sig | input | 4 | Signaling nibble for the fetched slot |
| sclk_o | output | 1 | Bit clock, possibly gapped |
| sfp_o | output | 1 | Frame pulse |
| sdat_o | output | 1 | Serial payload |
| ssig_o | output | 1 | Serial signaling |

## Verification
The hardest case to reach is the multiframe boundary with the rising-edge pulse select. There, the frame-0 pulse must appear in the last half of frame 15 of the previous multiframe. The same applies to the signaling multiframe pulse when it falls on a nonzero frame offset. Runs that check these cases hold each configuration for more than a full 8192-half multiframe, with several offsets and both polarities. Every half is compared against a position computed arithmetically from the count of edges since reset.

// File: rtl/e1rm_pkg.sv
package e1rm_pkg;

    typedef enum logic [2:0] {
        FP_FRAME    = 3'd0,
        FP_CRC_MF   = 3'd1,
        FP_SIG_MF   = 3'd2,
        FP_ANY_MF   = 3'd3,
        FP_OVERHEAD = 3'd4
    } fp_kind_e;

    typedef struct packed {
        logic sclk;
        logic sfp;
        logic sdat;
        logic ssig;
    } line_out_t;

    // Position views: the clock, the data and the pulse each look at a
    // slightly different half-bit position.
    localparam int unsigned VIEW_CLK  = 0;
    localparam int unsigned VIEW_DAT  = 1;
    localparam int unsigned VIEW_FP   = 2;
    localparam int unsigned NUM_VIEWS = 3;

endpackage

// File: rtl/e1rm_half_counter.sv
module e1rm_half_counter #(
    parameter int unsigned TOTAL = 8192,
    parameter int unsigned POS_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_d
);
    localparam logic [POS_W-1:0] LAST = POS_W'(TOTAL - 1);

    always_comb begin
        pos_d = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_d;
    end
endmodule

// File: rtl/e1rm_slot_decode.sv
module e1rm_slot_decode #(
    parameter int unsigned TS_BITS = 8,
    parameter int unsigned NUM_TS  = 32,
    parameter int unsigned POS_W   = 13,
    parameter int unsigned BIT_W   = 3,
    parameter int unsigned TS_W    = 5,
    parameter int unsigned MF_W    = 4
) (
    input  logic [POS_W-1:0] pos,
    output logic [BIT_W-1:0] bit_idx,
    output logic [TS_W-1:0]  ts_idx,
    output logic [MF_W-1:0]  frm_idx
);
    localparam logic [POS_W-1:0] TSB     = POS_W'(TS_BITS);
    localparam logic [POS_W-1:0] NTS     = POS_W'(NUM_TS);
    localparam logic [POS_W-1:0] FRM_LEN = POS_W'(TS_BITS * NUM_TS);

    logic [POS_W-1:0] bit_num;

    always_comb begin
        bit_num = pos >> 1;
        bit_idx = BIT_W'(bit_num % TSB);
        ts_idx  = TS_W'((bit_num / TSB) % NTS);
        frm_idx = MF_W'(bit_num / FRM_LEN);
    end
endmodule

// File: rtl/e1rm_gap_ctrl.sv
module e1rm_gap_ctrl #(
    parameter int unsigned NUM_TS  = 32,
    parameter int unsigned TS_BITS = 8,
    parameter int unsigned TS_W    = 5,
    parameter int unsigned BIT_W   = 3
) (
    input  logic              gap_en,
    input  logic              gap_ts,
    input  logic              gap_b8,
    input  logic [NUM_TS-1:0] gap_mask,
    input  logic [TS_W-1:0]   ts_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              gapped
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TS_BITS - 1);

    logic slot_sel;
    logic last_bit;

    always_comb begin
        slot_sel = gap_mask[ts_idx];
        last_bit = (bit_idx == LAST_BIT);
        // Whole-slot gapping covers the bit-8 case, so it wins when both are set.
        gapped   = gap_en & slot_sel & (gap_ts | (gap_b8 & last_bit));
    end
endmodule

// File: rtl/e1rm_fp_decode.sv
module e1rm_fp_decode
    import e1rm_pkg::*;
#(
    parameter int unsigned NUM_TS = 32,
    parameter int unsigned TS_W   = 5,
    parameter int unsigned BIT_W  = 3,
    parameter int unsigned MF_W   = 4
) (
    input  logic [2:0]       fp_sel,
    input  logic [MF_W-1:0]  smf_align,
    input  logic [TS_W-1:0]  ts_idx,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic [MF_W-1:0]  frm_idx,
    output logic             active
);
    localparam logic [TS_W-1:0] MID_TS = TS_W'(NUM_TS / 2);

    logic frame_start;
    logic crc_start;
    logic sig_start;
    logic overhead;

    always_comb begin
        frame_start = (ts_idx == '0) && (bit_idx == '0);
        crc_start   = frame_start && (frm_idx == '0);
        sig_start   = frame_start && (frm_idx == smf_align);
        overhead    = (ts_idx == '0) || (ts_idx == MID_TS);
        case (fp_sel)
            FP_FRAME:    active = frame_start;
            FP_CRC_MF:   active = crc_start;
            FP_SIG_MF:   active = sig_start;
            FP_ANY_MF:   active = crc_start | sig_start;
            FP_OVERHEAD: active = overhead;
            default:     active = 1'b0;
        endcase
    end
endmodule

// File: rtl/e1rm_rx_master_timing.sv
module e1rm_rx_master_timing
    import e1rm_pkg::*;
#(
    parameter int unsigned NUM_TS   = 32,
    parameter int unsigned TS_BITS  = 8,
    parameter int unsigned SIG_BITS = 4,
    parameter int unsigned MF_LEN   = 16,
    localparam int unsigned BIT_W   = $clog2(TS_BITS),
    localparam int unsigned TS_W    = $clog2(NUM_TS),
    localparam int unsigned MF_W    = $clog2(MF_LEN),
    localparam int unsigned SIG_W   = $clog2(SIG_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gap_en,
    input  logic                gap_ts,
    input  logic                gap_b8,
    input  logic [NUM_TS-1:0]   gap_mask,
    input  logic [2:0]          fp_sel,
    input  logic                fp_inv,
    input  logic                fp_edge,
    input  logic                dat_edge,
    input  logic [MF_W-1:0]     smf_align,
    output logic [TS_W-1:0]     fetch_ts,
    output logic [MF_W-1:0]     fetch_frm,
    input  logic [TS_BITS-1:0]  fetch_data,
    input  logic [SIG_BITS-1:0] fetch_sig,
    output logic                sclk_o,
    output logic                sfp_o,
    output logic                sdat_o,
    output logic                ssig_o
);
    localparam int unsigned HALF_TOTAL = 2 * NUM_TS * TS_BITS * MF_LEN;
    localparam int unsigned POS_W      = $clog2(HALF_TOTAL);
    localparam logic [POS_W-1:0] LAST  = POS_W'(HALF_TOTAL - 1);
    localparam logic [POS_W-1:0] ONE   = POS_W'(1);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(TS_BITS - 1);
    localparam logic [BIT_W-1:0] SIG_SPAN = BIT_W'(SIG_BITS);
    localparam logic [SIG_W-1:0] SIG_TOP = SIG_W'(SIG_BITS - 1);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;

    e1rm_half_counter #(.TOTAL(HALF_TOTAL), .POS_W(POS_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .pos_q (pos_q),
        .pos_d (pos_d)
    );

    // Next-half positions as seen by each view: data lags by one half
    // on the rising-edge select, the pulse leads by one half.
    logic [POS_W-1:0] view_pos [NUM_VIEWS];
    logic [BIT_W-1:0] bit_v    [NUM_VIEWS];
    logic [TS_W-1:0]  ts_v     [NUM_VIEWS];
    logic [MF_W-1:0]  frm_v    [NUM_VIEWS];
    logic             gap_v    [VIEW_FP];

    always_comb begin
        view_pos[VIEW_CLK] = pos_d;
        if (dat_edge && (pos_d == '0)) view_pos[VIEW_DAT] = LAST;
        else if (dat_edge)             view_pos[VIEW_DAT] = pos_d - ONE;
        else                           view_pos[VIEW_DAT] = pos_d;
        if (fp_edge && (pos_d == LAST)) view_pos[VIEW_FP] = '0;
        else if (fp_edge)               view_pos[VIEW_FP] = pos_d + ONE;
        else                            view_pos[VIEW_FP] = pos_d;
    end

    for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
        e1rm_slot_decode #(
            .TS_BITS(TS_BITS), .NUM_TS(NUM_TS), .POS_W(POS_W),
            .BIT_W(BIT_W), .TS_W(TS_W), .MF_W(MF_W)
        ) u_dec (
            .pos     (view_pos[v]),
            .bit_idx (bit_v[v]),
            .ts_idx  (ts_v[v]),
            .frm_idx (frm_v[v])
        );
        if (v < VIEW_FP) begin : g_gap
            e1rm_gap_ctrl #(
                .NUM_TS(NUM_TS), .TS_BITS(TS_BITS), .TS_W(TS_W), .BIT_W(BIT_W)
            ) u_gap (
                .gap_en   (gap_en),
                .gap_ts   (gap_ts),
                .gap_b8   (gap_b8),
                .gap_mask (gap_mask),
                .ts_idx   (ts_v[v]),
                .bit_idx  (bit_v[v]),
                .gapped   (gap_v[v])
            );
        end
    end

    logic unused_clk_frm;
    assign unused_clk_frm = ^frm_v[VIEW_CLK];

    logic fp_active;

    e1rm_fp_decode #(
        .NUM_TS(NUM_TS), .TS_W(TS_W), .BIT_W(BIT_W), .MF_W(MF_W)
    ) u_fp (
        .fp_sel    (fp_sel),
        .smf_align (smf_align),
        .ts_idx    (ts_v[VIEW_FP]),
        .bit_idx   (bit_v[VIEW_FP]),
        .frm_idx   (frm_v[VIEW_FP]),
        .active    (fp_active)
    );

    assign fetch_ts  = ts_v[VIEW_DAT];
    assign fetch_frm = frm_v[VIEW_DAT];

    line_out_t out_q;
    line_out_t out_d;
    logic [BIT_W-1:0] dat_sel;
    logic [SIG_W-1:0] sig_sel;

    always_comb begin
        out_d   = out_q;
        dat_sel = TOP_BIT - bit_v[VIEW_DAT];
        sig_sel = SIG_TOP - SIG_W'(bit_v[VIEW_DAT]);
        out_d.sclk = pos_d[0] & ~gap_v[VIEW_CLK];
        out_d.sfp  = fp_active ^ fp_inv;
        if (gap_v[VIEW_DAT]) begin
            out_d.sdat = 1'b0;
            out_d.ssig = 1'b0;
        end else begin
            out_d.sdat = fetch_data[dat_sel];
            out_d.ssig = (bit_v[VIEW_DAT] < SIG_SPAN) ? fetch_sig[sig_sel] : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign sclk_o = out_q.sclk;
    assign sfp_o  = out_q.sfp;
    assign sdat_o = out_q.sdat;
    assign ssig_o = out_q.ssig;

    // Configuration bundle used to qualify the stability checks below.
    logic [NUM_TS+MF_W+7:0] cfg_bus;
    assign cfg_bus = {gap_en, gap_ts, gap_b8, gap_mask, fp_sel, fp_inv, smf_align};

    // R2
    sclk_single_high_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_o |=> !sclk_o);

    // R5
    ungapped_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!gap_en && $past(!gap_en) && !sclk_o) |=> sclk_o);

    // R6
    data_half_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(dat_edge) && !$past(dat_edge, 2)
         && ($past(cfg_bus) == $past(cfg_bus, 2)) && pos_q[0])
        |-> $stable({sdat_o, ssig_o}));

    // R8
    pulse_half_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && ($past(fp_edge) == $past(fp_edge, 2))
         && ($past(cfg_bus) == $past(cfg_bus, 2)) && (pos_q[0] != $past(fp_edge)))
        |-> $stable(sfp_o));

    // R9
    pulse_unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        (fp_sel > 3'd4) |=> (sfp_o == $past(fp_inv)));

endmodule

// File: tb/e1rm_rx_master_timing_test.sv
module e1rm_rx_master_timing_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gap_en = 1'b0, gap_ts = 1'b0, gap_b8 = 1'b0;
    logic [31:0] gap_mask = '0;
    logic [2:0]  fp_sel = '0;
    logic        fp_inv = 1'b0, fp_edge = 1'b0, dat_edge = 1'b0;
    logic [3:0]  smf_align = '0;
    logic [4:0]  fetch_ts;
    logic [3:0]  fetch_frm;
    logic [7:0]  fetch_data;
    logic [3:0]  fetch_sig;
    logic        sclk_o, sfp_o, sdat_o, ssig_o;
    int          seed = 0;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    e1rm_rx_master_timing uut (
        .clk(clk), .rst(rst), .gap_en(gap_en), .gap_ts(gap_ts), .gap_b8(gap_b8),
        .gap_mask(gap_mask), .fp_sel(fp_sel), .fp_inv(fp_inv), .fp_edge(fp_edge),
        .dat_edge(dat_edge), .smf_align(smf_align), .fetch_ts(fetch_ts),
        .fetch_frm(fetch_frm), .fetch_data(fetch_data), .fetch_sig(fetch_sig),
        .sclk_o(sclk_o), .sfp_o(sfp_o), .sdat_o(sdat_o), .ssig_o(ssig_o)
    );

    function automatic int pat_byte(int ts, int fr);
        return (ts * 29 + fr * 7 + seed) & 255;
    endfunction

    function automatic int pat_sig(int ts, int fr);
        return (ts * 3 + fr + seed) & 15;
    endfunction

    // Slot store model answering the fetch port.
    always_comb begin
        fetch_data = 8'(pat_byte(int'(fetch_ts), int'(fetch_frm)));
        fetch_sig  = 4'(pat_sig(int'(fetch_ts), int'(fetch_frm)));
    end

    function automatic int bit_of(int h, int off);
        return ((h + off + 8192) % 8192) / 2;
    endfunction

    function automatic bit is_gapped(int b);
        int ts = (b / 8) % 32;
        int bp = b % 8;
        return gap_en && gap_mask[ts] && (gap_ts || (gap_b8 && bp == 7));
    endfunction

    task automatic check(input logic act, input logic exp, input string tag, input int h);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s half %0d actual %0b expected %0b", tag, h, act, exp);
        end
    endtask

    task automatic run(input bit fe, input bit de, input int sel, input bit inv,
                       input bit gen, input bit gts, input bit gb8,
                       input logic [31:0] mask, input int smf, input int sd,
                       input int ncyc);
        rst = 1'b1;
        fp_edge = fe; dat_edge = de; fp_sel = 3'(sel); fp_inv = inv;
        gap_en = gen; gap_ts = gts; gap_b8 = gb8; gap_mask = mask;
        smf_align = 4'(smf); seed = sd;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(sclk_o, 1'b0, "R1 reset sclk", 0);
        check(sfp_o,  1'b0, "R1 reset sfp", 0);
        check(sdat_o, 1'b0, "R1 reset sdat", 0);
        check(ssig_o, 1'b0, "R1 reset ssig", 0);
        rst = 1'b0;
        for (int n = 1; n <= ncyc; n++) begin
            int h, b, bp, ts, fr, byt, sg;
            logic e_clk, e_dat, e_sig, e_fp, first;
            @(negedge clk);
            h = n % 8192;
            // R2 R3 R4 R5 clock and gapping
            b = bit_of(h, 0);
            e_clk = ((h % 2) == 1) && !is_gapped(b);
            check(sclk_o, e_clk, "R2/R3/R4/R5 clock", h);
            // R6 R7 data and signaling
            b = bit_of(h, de ? -1 : 0);
            bp = b % 8; ts = (b / 8) % 32; fr = b / 256;
            byt = pat_byte(ts, fr); sg = pat_sig(ts, fr);
            if (is_gapped(b)) begin
                e_dat = 1'b0; e_sig = 1'b0;
            end else begin
                e_dat = byt[7 - bp];
                e_sig = (bp < 4) ? sg[3 - bp] : 1'b0;
            end
            check(sdat_o, e_dat, "R6 data", h);
            check(ssig_o, e_sig, "R7 signaling", h);
            // R8 R9 R10 frame pulse
            b = bit_of(h, fe ? 1 : 0);
            bp = b % 8; ts = (b / 8) % 32; fr = b / 256;
            first = (ts == 0) && (bp == 0);
            case (sel)
                0: e_fp = first;
                1: e_fp = first && fr == 0;
                2: e_fp = first && fr == smf;
                3: e_fp = first && (fr == 0 || fr == smf);
                4: e_fp = (ts == 0) || (ts == 16);
                default: e_fp = 1'b0;
            endcase
            check(sfp_o, e_fp ^ inv, "R8/R9/R10 pulse", h);
        end
    endtask

    initial begin
        //   fe de sel inv gen gts gb8 mask          smf sd  cycles
        run(0, 0, 0, 0, 0, 0, 0, 32'h0000_0000, 0, 3,  1100);
        run(1, 0, 0, 1, 1, 1, 0, 32'h8001_2345, 0, 11, 1100);  // R3
        run(0, 1, 4, 0, 1, 0, 1, 32'h5A5A_0F0F, 0, 17, 1100);  // R4
        run(1, 1, 4, 1, 1, 1, 1, 32'h8001_2345, 0, 23, 1100);  // R3 over R4
        run(0, 1, 5, 1, 0, 1, 1, 32'hFFFF_FFFF, 0, 31, 1100);  // R5
        run(1, 0, 6, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 41, 1100);  // R5 R9
        run(0, 0, 7, 1, 1, 1, 0, 32'hFFFF_FFFF, 0, 53, 1100);  // R3 all gapped
        run(0, 0, 1, 0, 0, 0, 0, 32'h0000_0000, 0, 61, 8400);  // R9 CRC
        run(1, 0, 1, 1, 1, 0, 1, 32'h0001_0001, 0, 67, 8400);  // R8 wrap
        run(1, 0, 2, 1, 0, 0, 0, 32'h0000_0000, 5, 71, 8400);  // R9 signaling
        run(0, 1, 3, 0, 0, 0, 0, 32'h0000_0000, 9, 79, 8400);  // R9 both
        run(1, 1, 3, 0, 0, 0, 0, 32'h0000_0000, 15, 83, 8400); // R10
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule